// File: doc/BRIEF.md
# Configuration Port Unlock Controller

This block guards an indexed configuration register space that a host reaches through a pair of byte-wide I/O addresses: an index port and, one address above it, a data port. The space stays closed until the host writes a two-byte enter key to the index port. While it is closed, reads return all ones and data writes do nothing. Once it is open, the host writes a register index to the index port and then reads or writes that register through the data port. A single exit key written to the index port closes the space again.

The space holds two kinds of registers. Global registers carry fixed chip and vendor identification, a read-only report of which port pair is active, and a logical-device-number register. That number picks which bank of per-device registers the data port reaches. Each bank holds an enable bit, a 16-bit I/O base address and a 4-bit interrupt number, and drives them out of the block to the function logic it configures. A static strap input moves the port pair from its primary location to an alternate one.

Top module: `cfgport_guard`

## Requirements
- R1: The space opens (`cfg_open` goes high) only after the index port is written with 0x87 on two index writes in a row. `cfg_open` is high from the cycle after the second write.
- R2: Between the two enter keys, an index write of any other value or any data-port write restarts the sequence. After that, two further 0x87 writes are needed.
- R3: While the space is open, an index write of 0xAA closes it. `cfg_open` is low from the next cycle. Any other index write while open sets the register index.
- R4: While closed, data-port reads return 0xFF and data-port writes change no register. Index-port reads return 0xFF while closed and the current index while open.
- R5: With `strap_alt` low the active pair is 0x002E/0x002F. With it high the pair is 0x004E/0x004F. Accesses to any other address, including the inactive pair, are ignored and produce no read response.
- R6: A read of either active port returns `host_rdata` with `host_rvalid` high exactly one cycle after the `host_rd` cycle. `host_rvalid` is low otherwise.
- R7: Global index 0x07 is a read/write 8-bit logical device number, reset value 0x00.
- R8: Global indices 0x20, 0x21, 0x23 and 0x24 read 0x04, 0x08, 0x19 and 0x34 (chip ID high/low, vendor ID high/low). Writes to them are ignored.
- R9: Global index 0x25 reads with bit 4 equal to `strap_alt` and all other bits zero, and is read-only.
- R10: For a device number below NUM_DEV, the per-device registers behave as follows. Index 0x30 bit 0 is the enable and reads back as {7'b0, en}. 0x60 and 0x61 are the high and low base-address bytes. 0x70 bits 3:0 are the IRQ number and read back as {4'b0, irq}. Device n drives `dev_en[n]`, `dev_base[16n+15:16n]` and `dev_irq[4n+3:4n]`. All of these reset to zero.
- R11: Unimplemented indices, and per-device indices while the device number is NUM_DEV or above, read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_alt | input | 1 | Selects the alternate port pair (static) |
| host_addr | input | 16 | I/O address of the access |
| host_wr | input | 1 | Write strobe, one cycle per byte |
| host_rd | input | 1 | Read strobe, one cycle per byte |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read response strobe |
| cfg_open | output | 1 | Configuration space unlocked |
| dev_en | output | NUM_DEV | Per-device enable bits |
| dev_base | output | 16*NUM_DEV | Per-device I/O base addresses |
| dev_irq | output | 4*NUM_DEV | Per-device IRQ numbers |

## Verification
The assertions assume that the host never raises `host_wr` and `host_rd` in the same cycle, and that `strap_alt` changes only while reset is held. Under those conditions, the unlock and read-response properties can relate each strobe to the cycle that follows it. The bench drives every access as a single strobe cycle followed by an idle cycle. It changes the strap only across a full reset.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

  typedef enum logic [1:0] {
    LK_CLOSED = 2'd0,
    LK_HALF   = 2'd1,
    LK_OPEN   = 2'd2
  } lock_state_e;

  localparam logic [7:0] KEY_ENTER   = 8'h87;
  localparam logic [7:0] KEY_EXIT    = 8'hAA;

  localparam logic [7:0] IX_LDN      = 8'h07;
  localparam logic [7:0] IX_CHIP_HI  = 8'h20;
  localparam logic [7:0] IX_CHIP_LO  = 8'h21;
  localparam logic [7:0] IX_VEND_HI  = 8'h23;
  localparam logic [7:0] IX_VEND_LO  = 8'h24;
  localparam logic [7:0] IX_PORTSEL  = 8'h25;

  localparam logic [7:0] IX_DEV_EN   = 8'h30;
  localparam logic [7:0] IX_BASE_HI  = 8'h60;
  localparam logic [7:0] IX_BASE_LO  = 8'h61;
  localparam logic [7:0] IX_IRQ      = 8'h70;

  localparam int PORTSEL_BIT = 4;

  function automatic logic is_bank_index(input logic [7:0] ix);
    return (ix == IX_DEV_EN) || (ix == IX_BASE_HI) ||
           (ix == IX_BASE_LO) || (ix == IX_IRQ);
  endfunction

endpackage

// File: rtl/cfgp_unlock.sv
module cfgp_unlock
  import cfgp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic       dat_wr,
  input  logic [7:0] wdata,
  output logic       cfg_open
);

  lock_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LK_CLOSED: begin
        if (idx_wr && wdata == KEY_ENTER) state_d = LK_HALF;
      end
      LK_HALF: begin
        if (idx_wr) state_d = (wdata == KEY_ENTER) ? LK_OPEN : LK_CLOSED;
        else if (dat_wr) state_d = LK_CLOSED;
      end
      LK_OPEN: begin
        if (idx_wr && wdata == KEY_EXIT) state_d = LK_CLOSED;
      end
      default: state_d = LK_CLOSED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LK_CLOSED;
    else        state_q <= state_d;
  end

  assign cfg_open = (state_q == LK_OPEN);

  // R1
  open_needs_two_keys_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> ($past(state_q) == LK_HALF && $past(idx_wr) && $past(wdata) == KEY_ENTER));

  // R2
  half_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LK_HALF && ((idx_wr && wdata != KEY_ENTER) || dat_wr)) |=> (state_q == LK_CLOSED));

  // R3
  exit_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && idx_wr && wdata == KEY_EXIT) |=> !cfg_open);

endmodule

// File: rtl/cfgp_global_regs.sv
module cfgp_global_regs
  import cfgp_pkg::*;
#(
  parameter logic [15:0] CHIP_ID   = 16'h0408,
  parameter logic [15:0] VENDOR_ID = 16'h1934
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_sel,
  input  logic [7:0] index,
  input  logic [7:0] wdata,
  input  logic       strap_alt,
  output logic [7:0] ldn,
  output logic       hit,
  output logic [7:0] rdata
);

  logic [7:0] ldn_q, ldn_d;
  logic       ldn_we;

  assign ldn_we = wr_sel && (index == IX_LDN);

  always_comb begin
    ldn_d = ldn_q;
    if (ldn_we) ldn_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ldn_q <= '0;
    else        ldn_q <= ldn_d;
  end

  always_comb begin
    hit   = 1'b1;
    rdata = 8'h00;
    unique case (index)
      IX_LDN:     rdata = ldn_q;
      IX_CHIP_HI: rdata = CHIP_ID[15:8];
      IX_CHIP_LO: rdata = CHIP_ID[7:0];
      IX_VEND_HI: rdata = VENDOR_ID[15:8];
      IX_VEND_LO: rdata = VENDOR_ID[7:0];
      IX_PORTSEL: rdata[PORTSEL_BIT] = strap_alt;
      default:    hit = 1'b0;
    endcase
  end

  assign ldn = ldn_q;

  // R7
  ldn_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ldn_q) |-> ($past(wr_sel) && $past(index) == IX_LDN));

endmodule

// File: rtl/cfgp_dev_bank.sv
module cfgp_dev_bank
  import cfgp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel,
  input  logic        wr_sel,
  input  logic [7:0]  index,
  input  logic [7:0]  wdata,
  output logic        en,
  output logic [15:0] base,
  output logic [3:0]  irq,
  output logic [7:0]  rdata
);

  logic        en_q, en_d;
  logic [15:0] base_q, base_d;
  logic [3:0]  irq_q, irq_d;
  logic        we;

  assign we = sel && wr_sel;

  always_comb begin
    en_d   = en_q;
    base_d = base_q;
    irq_d  = irq_q;
    if (we) begin
      unique case (index)
        IX_DEV_EN:  en_d         = wdata[0];
        IX_BASE_HI: base_d[15:8] = wdata;
        IX_BASE_LO: base_d[7:0]  = wdata;
        IX_IRQ:     irq_d        = wdata[3:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      base_q <= '0;
      irq_q  <= '0;
    end else begin
      en_q   <= en_d;
      base_q <= base_d;
      irq_q  <= irq_d;
    end
  end

  always_comb begin
    unique case (index)
      IX_DEV_EN:  rdata = {7'b0, en_q};
      IX_BASE_HI: rdata = base_q[15:8];
      IX_BASE_LO: rdata = base_q[7:0];
      IX_IRQ:     rdata = {4'b0, irq_q};
      default:    rdata = 8'h00;
    endcase
  end

  assign en   = en_q;
  assign base = base_q;
  assign irq  = irq_q;

  // R10
  en_change_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(en_q) |-> ($past(sel) && $past(wr_sel) && $past(index) == IX_DEV_EN));

  // R10
  base_change_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(base_q) |-> ($past(sel) && $past(wr_sel) && is_bank_index($past(index))));

endmodule

// File: rtl/cfgport_guard.sv
module cfgport_guard
  import cfgp_pkg::*;
#(
  parameter int          NUM_DEV    = 8,
  parameter logic [15:0] PRI_INDEX  = 16'h002E,
  parameter logic [15:0] ALT_INDEX  = 16'h004E,
  parameter logic [15:0] CHIP_ID    = 16'h0408,
  parameter logic [15:0] VENDOR_ID  = 16'h1934
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   strap_alt,
  input  logic [15:0]            host_addr,
  input  logic                   host_wr,
  input  logic                   host_rd,
  input  logic [7:0]             host_wdata,
  output logic [7:0]             host_rdata,
  output logic                   host_rvalid,
  output logic                   cfg_open,
  output logic [NUM_DEV-1:0]     dev_en,
  output logic [16*NUM_DEV-1:0]  dev_base,
  output logic [4*NUM_DEV-1:0]   dev_irq
);

  localparam logic [7:0] NUM_DEV_B = 8'(NUM_DEV);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  // port decode
  logic [15:0] idx_addr, dat_addr;
  logic        idx_wr, dat_wr, idx_rd, dat_rd, cfg_wr;

  assign idx_addr = strap_alt ? ALT_INDEX : PRI_INDEX;
  assign dat_addr = idx_addr + 16'd1;
  assign idx_wr   = host_wr && (host_addr == idx_addr);
  assign dat_wr   = host_wr && (host_addr == dat_addr);
  assign idx_rd   = host_rd && (host_addr == idx_addr);
  assign dat_rd   = host_rd && (host_addr == dat_addr);
  assign cfg_wr   = dat_wr && cfg_open;

  cfgp_unlock u_unlock (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .idx_wr   (idx_wr),
    .dat_wr   (dat_wr),
    .wdata    (host_wdata),
    .cfg_open (cfg_open)
  );

  // index latch
  logic [7:0] index_q, index_d;

  always_comb begin
    index_d = index_q;
    if (cfg_open && idx_wr && host_wdata != KEY_EXIT) index_d = host_wdata;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) index_q <= '0;
    else          index_q <= index_d;
  end

  // global registers
  logic [7:0] ldn, glob_rdata;
  logic       glob_hit;

  cfgp_global_regs #(
    .CHIP_ID   (CHIP_ID),
    .VENDOR_ID (VENDOR_ID)
  ) u_global (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .wr_sel    (cfg_wr),
    .index     (index_q),
    .wdata     (host_wdata),
    .strap_alt (strap_alt),
    .ldn       (ldn),
    .hit       (glob_hit),
    .rdata     (glob_rdata)
  );

  // per-device banks
  logic [7:0] bank_rdata [NUM_DEV];

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_bank
    logic        en_w;
    logic [15:0] base_w;
    logic [3:0]  irq_w;

    cfgp_dev_bank u_bank (
      .clk    (clk),
      .rst_n  (rst_i_n),
      .sel    (ldn == 8'(g)),
      .wr_sel (cfg_wr),
      .index  (index_q),
      .wdata  (host_wdata),
      .en     (en_w),
      .base   (base_w),
      .irq    (irq_w),
      .rdata  (bank_rdata[g])
    );

    assign dev_en[g]          = en_w;
    assign dev_base[16*g +: 16] = base_w;
    assign dev_irq[4*g +: 4]    = irq_w;
  end

  // read path
  logic [7:0] sel_bank_rdata, rd_mux;

  always_comb begin
    sel_bank_rdata = 8'h00;
    for (int i = 0; i < NUM_DEV; i++) begin
      if (ldn == 8'(i)) sel_bank_rdata = bank_rdata[i];
    end
  end

  always_comb begin
    if (!cfg_open)                                     rd_mux = 8'hFF;
    else if (idx_rd)                                   rd_mux = index_q;
    else if (glob_hit)                                 rd_mux = glob_rdata;
    else if (is_bank_index(index_q) && ldn < NUM_DEV_B) rd_mux = sel_bank_rdata;
    else                                               rd_mux = 8'h00;
  end

  logic [7:0] rdata_q, rdata_d;
  logic       rvalid_q, rvalid_d, rd_any;

  assign rd_any   = idx_rd || dat_rd;
  assign rvalid_d = rd_any;

  always_comb begin
    rdata_d = rdata_q;
    if (rd_any) rdata_d = rd_mux;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rdata_q  <= rdata_d;
      rvalid_q <= rvalid_d;
    end
  end

  assign host_rdata  = rdata_q;
  assign host_rvalid = rvalid_q;

  // R4
  locked_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    ((host_rd && (host_addr == idx_addr || host_addr == dat_addr)) && !cfg_open)
      |=> (host_rvalid && host_rdata == 8'hFF));

  // R6
  rvalid_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !host_rd |=> !host_rvalid);

  // R4
  locked_no_index_change_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !cfg_open |=> $stable(index_q));

endmodule

// File: tb/tb_cfgport_guard.sv
module tb_cfgport_guard;

  localparam int NUM_DEV = 8;

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic                  strap_alt;
  logic [15:0]           host_addr;
  logic                  host_wr, host_rd;
  logic [7:0]            host_wdata;
  logic [7:0]            host_rdata;
  logic                  host_rvalid;
  logic                  cfg_open;
  logic [NUM_DEV-1:0]    dev_en;
  logic [16*NUM_DEV-1:0] dev_base;
  logic [4*NUM_DEV-1:0]  dev_irq;

  always #5 clk = ~clk;

  cfgport_guard #(.NUM_DEV(NUM_DEV)) dut (
    .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt),
    .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .cfg_open(cfg_open), .dev_en(dev_en), .dev_base(dev_base), .dev_irq(dev_irq)
  );

  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;

  exp_t        sb_q[$];
  int          n_checks = 0;
  int          n_errors = 0;
  bit          done = 0;
  logic [15:0] ixp;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expectation per read response
  always @(negedge clk) begin
    if (rst_n && host_rvalid) begin
      if (sb_q.size() == 0) begin
        n_checks++;
        n_errors++;
        $display("FAIL R6: actual unexpected response 0x%0h expected none", host_rdata);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, {24'b0, host_rdata}, {24'b0, e.val});
      end
    end
  end

  task automatic host_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(logic [15:0] a, logic [7:0] exp, string tag);
    exp_t e;
    @(negedge clk);
    e.val = exp; e.tag = tag;
    sb_q.push_back(e);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic host_read_none(logic [15:0] a, string tag);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    check(tag, {31'b0, host_rvalid}, 32'd0);
  endtask

  task automatic unlock();
    host_write(ixp, 8'h87);
    host_write(ixp, 8'h87);
  endtask

  task automatic wr_reg(logic [7:0] ix, logic [7:0] v);
    host_write(ixp, ix);
    host_write(ixp + 16'd1, v);
  endtask

  task automatic rd_reg(logic [7:0] ix, logic [7:0] exp, string tag);
    host_write(ixp, ix);
    host_read(ixp + 16'd1, exp, tag);
  endtask

  task automatic do_reset(logic alt);
    rst_n = 1'b0; strap_alt = alt;
    host_wr = 1'b0; host_rd = 1'b0; host_addr = '0; host_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    ixp = 16'h002E;
    do_reset(1'b0);

    // reset state
    check("R1 reset closed", {31'b0, cfg_open}, 0);
    check("R10 reset enables", {24'b0, dev_en}, 0);
    host_read(16'h002F, 8'hFF, "R4 locked data read");
    host_read(16'h002E, 8'hFF, "R4 locked index read");

    // interrupted unlock
    host_write(ixp, 8'h87);
    host_write(ixp, 8'h55);
    host_write(ixp, 8'h87);
    check("R2 restart after other value", {31'b0, cfg_open}, 0);
    host_write(ixp, 8'h87);
    check("R1 open after two keys", {31'b0, cfg_open}, 1);
    host_write(ixp, 8'hAA);
    check("R3 exit key closes", {31'b0, cfg_open}, 0);
    host_write(ixp, 8'h87);
    host_write(ixp + 16'd1, 8'h00);
    host_write(ixp, 8'h87);
    check("R2 data write restarts", {31'b0, cfg_open}, 0);
    host_write(ixp, 8'hAA);

    // IDs and globals
    unlock();
    rd_reg(8'h20, 8'h04, "R8 chip hi");
    rd_reg(8'h21, 8'h08, "R8 chip lo");
    rd_reg(8'h23, 8'h19, "R8 vendor hi");
    rd_reg(8'h24, 8'h34, "R8 vendor lo");
    wr_reg(8'h20, 8'h77);
    rd_reg(8'h20, 8'h04, "R8 chip id read-only");
    rd_reg(8'h25, 8'h00, "R9 portsel primary");
    rd_reg(8'h22, 8'h00, "R11 unimplemented global");
    host_read(ixp, 8'h22, "R4 index read while open");

    // device banks
    wr_reg(8'h07, 8'h01);
    rd_reg(8'h07, 8'h01, "R7 ldn readback");
    wr_reg(8'h30, 8'hFF);
    wr_reg(8'h60, 8'h12);
    wr_reg(8'h61, 8'h34);
    wr_reg(8'h70, 8'hF5);
    rd_reg(8'h30, 8'h01, "R10 enable readback");
    rd_reg(8'h70, 8'h05, "R10 irq readback");
    rd_reg(8'h60, 8'h12, "R10 base hi");
    check("R10 dev_en out", {24'b0, dev_en}, 32'h02);
    check("R10 dev_base out", {16'b0, dev_base[31:16]}, 32'h1234);
    check("R10 dev_irq out", {28'b0, dev_irq[7:4]}, 32'h5);
    wr_reg(8'h31, 8'h5A);
    rd_reg(8'h31, 8'h00, "R11 unimplemented bank index");
    wr_reg(8'h07, 8'h03);
    rd_reg(8'h60, 8'h00, "R10 bank independence");
    wr_reg(8'h07, 8'h09);
    wr_reg(8'h30, 8'h01);
    rd_reg(8'h30, 8'h00, "R11 ldn out of range");
    check("R11 out-of-range write ignored", {24'b0, dev_en}, 32'h02);

    // locked writes ignored
    wr_reg(8'h07, 8'h02);
    host_write(ixp, 8'h30);
    host_write(ixp, 8'hAA);
    host_write(ixp + 16'd1, 8'h01);
    check("R4 locked write ignored", {24'b0, dev_en}, 32'h02);
    unlock();
    host_read(ixp, 8'h30, "R4 index kept across lock");
    rd_reg(8'h30, 8'h00, "R4 locked write left register");
    host_write(ixp, 8'hAA);

    // alternate port pair
    do_reset(1'b1);
    ixp = 16'h004E;
    host_write(16'h002E, 8'h87);
    host_write(16'h002E, 8'h87);
    check("R5 inactive pair ignored", {31'b0, cfg_open}, 0);
    unlock();
    check("R5 alternate pair opens", {31'b0, cfg_open}, 1);
    rd_reg(8'h25, 8'h10, "R9 portsel alternate");
    host_read_none(16'h002F, "R5 inactive pair no response");
    rd_reg(8'h07, 8'h00, "R7 ldn reset value");

    repeat (3) @(negedge clk);
    check("R6 all responses seen", sb_q.size(), 0);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule